// File: doc/BRIEF.md
# Bundle Lane Legality Checker

This block sits in the decode stage of a core that runs explicitly bundled instruction groups. Each cycle it sees the active pipeline mode and a bundle of up to three instructions, already reduced to 3-bit class tags. It decides whether the whole bundle may go out in parallel on the lanes that the mode provides. When it may, the block raises one lane-valid bit for each instruction in the bundle. When it may not, the block asserts a scalar fallback flag and offers only the first instruction, so the core can walk the bundle one instruction at a time instead of taking a fault.

Each lane accepts its own set of classes, and that set depends on the mode. A memory operation takes up extra lane capacity, because the core has a single memory port. Lane 2 may take a floating-point operation in the three-lane mode, but only when lane 1 is not also holding one. The decision is purely combinational: the outputs follow the inputs within the same cycle.

Top module: `bundle_lane_check`

## Requirements
- R1: With a bundle length of 0, lane_valid_o is 3'b000 and scalar_fallback_o is 0 in every mode.
- R2: With a bundle length of 1, lane_valid_o is 3'b001 and scalar_fallback_o is 0 for any tag in any mode.
- R3: In mode 0 (scalar), and in the unused mode value 3, any bundle of two or more instructions falls back.
- R4: Tags sit in bundle_tags_i, slot k in bits [3k+2:3k], encoded ALU=0, SHIFT=1, CONV_BASIC=2, CONV_OTHER=3, MEM=4, FPU=5, BRANCH=6, NOP=7. In mode 1 (two lanes), lane 2 accepts ALU, SHIFT, CONV_BASIC, CONV_OTHER and NOP, and a three-instruction bundle always falls back.
- R5: In mode 1, a two-instruction bundle that holds a MEM in either slot falls back.
- R6: In mode 2 (three lanes), lane 2 accepts ALU, SHIFT, CONV_BASIC, CONV_OTHER and NOP, and lane 3 accepts only ALU, CONV_BASIC and NOP.
- R7: In mode 2, a three-instruction bundle holding a MEM falls back, and a two-instruction bundle with a MEM in slot 0 issues when slot 1 is otherwise acceptable.
- R8: In mode 2, an FPU tag in lane 2 is accepted exactly when the slot 0 tag is not FPU.
- R9: BRANCH and MEM tags are accepted only in lane 1 (slot 0).
- R10: A legal bundle of length n drives the low n bits of lane_valid_o high and scalar_fallback_o low; an illegal one drives lane_valid_o to 3'b001 and scalar_fallback_o high.
- R11: A bundle with two or more MEM tags always falls back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Active pipeline mode: 0 scalar, 1 two-lane, 2 three-lane, 3 treated as scalar |
| bundle_len_i | input | 2 | Number of instructions in the bundle (0 to 3), filled from slot 0 |
| bundle_tags_i | input | 9 | Class tags, slot k in bits [3k+2:3k] |
| lane_valid_o | output | 3 | Per-lane issue enable, bit k for lane k+1 |
| scalar_fallback_o | output | 1 | High when the bundle must be issued one instruction at a time |

## Verification
The bench targets the floating-point exception in lane 2, where a design that ignored the slot 0 tag would pair two FPU operations or reject a legal FPU pairing. It probes the memory capacity rules, where a checker that forgot a MEM eats lane 3 would issue a full three-wide bundle through the single memory port, and one that missed the two-lane rule would pair a MEM in mode 1. It also checks the split between lane 2 and lane 3 acceptance (SHIFT and CONV_OTHER allowed in lane 2 only), the fallback output shape, and mode 3 falling back like mode 0; a full sweep of all tags, lengths and modes against an independently written rule set catches any single miscoded entry.

// File: rtl/blc_pkg.sv
package blc_pkg;

  parameter int TAG_W     = 3;
  parameter int NUM_SLOTS = 3;
  parameter int MODE_W    = 2;
  parameter int LEN_W     = $clog2(NUM_SLOTS + 1);

  typedef enum logic [TAG_W-1:0] {
    CLS_ALU       = 3'd0,
    CLS_SHIFT     = 3'd1,
    CLS_CVT_BASIC = 3'd2,
    CLS_CVT_EXT   = 3'd3,
    CLS_MEM       = 3'd4,
    CLS_FPU       = 3'd5,
    CLS_BRANCH    = 3'd6,
    CLS_NOP       = 3'd7
  } cls_e;

  typedef enum logic [MODE_W-1:0] {
    MODE_SCALAR = 2'd0,
    MODE_DUAL   = 2'd1,
    MODE_TRIPLE = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  // Number of parallel lanes a mode offers before memory is considered.
  function automatic logic [LEN_W-1:0] mode_lanes(input logic [MODE_W-1:0] m);
    case (m)
      MODE_DUAL:   return LEN_W'(2);
      MODE_TRIPLE: return LEN_W'(3);
      default:     return LEN_W'(1);
    endcase
  endfunction

  // Lane capacity once a memory operation is present in the bundle.
  function automatic logic [LEN_W-1:0] lanes_after_mem(input logic [MODE_W-1:0] m,
                                                       input logic has_mem);
    logic [LEN_W-1:0] base;
    base = mode_lanes(m);
    if (has_mem && (base > LEN_W'(1))) return base - LEN_W'(1);
    return base;
  endfunction

  // Whether a lane (0-based) accepts a class tag; lead is the slot 0 tag.
  function automatic logic lane_takes(input logic [MODE_W-1:0] m,
                                      input int               lane,
                                      input logic [TAG_W-1:0] tag,
                                      input logic [TAG_W-1:0] lead);
    logic ok;
    ok = 1'b0;
    if (lane == 0) begin
      ok = 1'b1;
    end else if (lane == 1) begin
      case (tag)
        CLS_ALU, CLS_SHIFT, CLS_CVT_BASIC, CLS_CVT_EXT, CLS_NOP: ok = 1'b1;
        CLS_FPU: ok = (m == MODE_TRIPLE) && (lead != CLS_FPU);
        default: ok = 1'b0;
      endcase
    end else begin
      case (tag)
        CLS_ALU, CLS_CVT_BASIC, CLS_NOP: ok = 1'b1;
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  // Population count of a slot mask, sized to the length field.
  function automatic logic [LEN_W-1:0] count_hits(input logic [NUM_SLOTS-1:0] hits);
    logic [LEN_W-1:0] c;
    c = '0;
    for (int i = 0; i < NUM_SLOTS; i++) c = c + LEN_W'(hits[i]);
    return c;
  endfunction

endpackage

// File: rtl/blc_lane_gate.sv
module blc_lane_gate
  import blc_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [TAG_W-1:0]  lead_tag_i,
  input  logic              busy_i,
  output logic              ok_o
);

  logic takes;

  always_comb begin
    takes = lane_takes(mode_i, LANE, tag_i, lead_tag_i);
    ok_o  = !busy_i || takes;
  end

endmodule

// File: rtl/blc_mem_budget.sv
module blc_mem_budget
  import blc_pkg::*;
(
  input  logic [MODE_W-1:0]    mode_i,
  input  logic [NUM_SLOTS-1:0] mem_hit_i,
  output logic [LEN_W-1:0]     mem_cnt_o,
  output logic [LEN_W-1:0]     cap_o
);

  always_comb begin
    mem_cnt_o = count_hits(mem_hit_i);
    cap_o     = lanes_after_mem(mode_i, |mem_hit_i);
  end

endmodule

// File: rtl/blc_issue_resolve.sv
module blc_issue_resolve
  import blc_pkg::*;
(
  input  logic [LEN_W-1:0]     len_i,
  input  logic [LEN_W-1:0]     cap_i,
  input  logic [LEN_W-1:0]     mem_cnt_i,
  input  logic [NUM_SLOTS-1:0] slot_ok_i,
  output logic                 legal_o,
  output logic [NUM_SLOTS-1:0] lane_valid_o,
  output logic                 fallback_o
);

  logic fits;
  logic one_port;

  always_comb begin
    fits     = (len_i <= cap_i);
    one_port = (mem_cnt_i <= LEN_W'(1));
    legal_o  = fits && one_port && (&slot_ok_i);
    fallback_o = !legal_o;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (legal_o) lane_valid_o[k] = (LEN_W'(k) < len_i);
      else         lane_valid_o[k] = (k == 0);
    end
  end

endmodule

// File: rtl/bundle_lane_check.sv
module bundle_lane_check
  import blc_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] bundle_len_i,
  input  logic [8:0] bundle_tags_i,
  output logic [2:0] lane_valid_o,
  output logic       scalar_fallback_o
);

  logic [TAG_W-1:0]     slot_tag [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_busy;
  logic [NUM_SLOTS-1:0] mem_hit;
  logic [NUM_SLOTS-1:0] slot_ok;
  logic [LEN_W-1:0]     mem_cnt;
  logic [LEN_W-1:0]     lane_cap;
  logic                 bundle_legal;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign slot_tag[k]  = bundle_tags_i[k*TAG_W +: TAG_W];
    assign slot_busy[k] = (LEN_W'(k) < bundle_len_i);
    assign mem_hit[k]   = slot_busy[k] && (slot_tag[k] == CLS_MEM);

    blc_lane_gate #(.LANE(k)) u_gate (
      .mode_i     (mode_i),
      .tag_i      (slot_tag[k]),
      .lead_tag_i (slot_tag[0]),
      .busy_i     (slot_busy[k]),
      .ok_o       (slot_ok[k])
    );
  end

  blc_mem_budget u_budget (
    .mode_i    (mode_i),
    .mem_hit_i (mem_hit),
    .mem_cnt_o (mem_cnt),
    .cap_o     (lane_cap)
  );

  blc_issue_resolve u_resolve (
    .len_i        (bundle_len_i),
    .cap_i        (lane_cap),
    .mem_cnt_i    (mem_cnt),
    .slot_ok_i    (slot_ok),
    .legal_o      (bundle_legal),
    .lane_valid_o (lane_valid_o),
    .fallback_o   (scalar_fallback_o)
  );

endmodule

// File: rtl/bundle_lane_check_sva.sv
module bundle_lane_check_sva (
  input logic [1:0] mode_i,
  input logic [1:0] bundle_len_i,
  input logic [8:0] bundle_tags_i,
  input logic [2:0] lane_valid_o,
  input logic       scalar_fallback_o,
  input logic [2:0] slot_ok,
  input logic [1:0] mem_cnt,
  input logic [1:0] lane_cap,
  input logic       bundle_legal
);

  logic [2:0] t0, t1, t2;
  assign t0 = bundle_tags_i[2:0];
  assign t1 = bundle_tags_i[5:3];
  assign t2 = bundle_tags_i[8:6];

  always_comb begin
    // R1
    if (bundle_len_i == 2'd0)
      len0_idle_chk: assert (lane_valid_o == 3'b000 && !scalar_fallback_o);
    // R3
    if ((mode_i == 2'd0 || mode_i == 2'd3) && bundle_len_i >= 2'd2)
      scalar_mode_chk: assert (scalar_fallback_o);
    // R10
    if (scalar_fallback_o)
      fallback_shape_chk: assert (lane_valid_o == 3'b001);
    // R10
    fallback_legal_chk: assert (scalar_fallback_o == !bundle_legal);
    // R5
    if (mode_i == 2'd1 && bundle_len_i == 2'd2 && (t0 == 3'd4 || t1 == 3'd4))
      dual_mem_chk: assert (scalar_fallback_o);
    // R9
    if (lane_valid_o[1])
      lane2_branch_chk: assert (t1 != 3'd6 && t1 != 3'd4);
    // R9
    if (lane_valid_o[2])
      lane3_branch_chk: assert (t2 != 3'd6 && t2 != 3'd4);
    // R6
    if (lane_valid_o[2])
      lane3_shift_chk: assert (t2 != 3'd1 && t2 != 3'd3 && t2 != 3'd5);
    // R8
    if (lane_valid_o[1] && t1 == 3'd5)
      fpu_pair_chk: assert (t0 != 3'd5 && mode_i == 2'd2);
    // R11
    if (mem_cnt > 2'd1)
      one_port_chk: assert (scalar_fallback_o);
    // R7
    if (!scalar_fallback_o)
      cap_respect_chk: assert (bundle_len_i <= lane_cap && &slot_ok);
  end

endmodule

bind bundle_lane_check bundle_lane_check_sva sva_i (
  .mode_i            (mode_i),
  .bundle_len_i      (bundle_len_i),
  .bundle_tags_i     (bundle_tags_i),
  .lane_valid_o      (lane_valid_o),
  .scalar_fallback_o (scalar_fallback_o),
  .slot_ok           (slot_ok),
  .mem_cnt           (mem_cnt),
  .lane_cap          (lane_cap),
  .bundle_legal      (bundle_legal)
);

// File: tb/bundle_lane_check_tb_top.sv
module bundle_lane_check_tb_top;

  localparam logic [2:0] T_ALU = 3'd0, T_SHF = 3'd1, T_CVB = 3'd2, T_CVX = 3'd3,
                         T_MEM = 3'd4, T_FPU = 3'd5, T_BRA = 3'd6, T_NOP = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [1:0] blen = 2'd0;
  logic [8:0] tags = 9'd0;
  logic [2:0] lane_valid;
  logic       fallback;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bundle_lane_check dut_i (
    .mode_i            (mode),
    .bundle_len_i      (blen),
    .bundle_tags_i     (tags),
    .lane_valid_o      (lane_valid),
    .scalar_fallback_o (fallback)
  );

  task automatic apply(input logic [1:0] m, input logic [1:0] n,
                       input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
    @(negedge clk);
    mode = m; blen = n; tags = {c, b, a};
    #2;
  endtask

  task automatic check(input string req, input logic [2:0] exp_lv, input logic exp_fb);
    checks++;
    if (lane_valid !== exp_lv || fallback !== exp_fb) begin
      errors++;
      $display("FAIL %s mode=%0d len=%0d tags=%o: got lv=%b fb=%b, expected lv=%b fb=%b",
               req, mode, blen, tags, lane_valid, fallback, exp_lv, exp_fb);
    end
  endtask

  // Independent rule set, written per mode.
  function automatic logic [3:0] ref_out(input logic [1:0] m, input logic [1:0] n,
                                         input logic [2:0] a, input logic [2:0] b,
                                         input logic [2:0] c);
    logic ok;
    int nm;
    if (n == 2'd0) return 4'b0000;
    if (n == 2'd1) return 4'b0001;
    ok = 1'b0;
    if (m == 2'd1) begin
      ok = (n == 2'd2) && (a != T_MEM) &&
           (b inside {T_ALU, T_SHF, T_CVB, T_CVX, T_NOP});
    end else if (m == 2'd2) begin
      nm = (a == T_MEM) + (b == T_MEM) + ((n == 2'd3) && (c == T_MEM));
      ok = (b inside {T_ALU, T_SHF, T_CVB, T_CVX, T_NOP}) || (b == T_FPU && a != T_FPU);
      if (n == 2'd3) ok = ok && (c inside {T_ALU, T_CVB, T_NOP}) && (nm == 0);
      if (nm > 1) ok = 1'b0;
    end
    if (!ok) return 4'b1001;
    return (n == 2'd2) ? 4'b0011 : 4'b0111;
  endfunction

  task automatic t_idle();
    for (int m = 0; m < 4; m++) begin
      apply(2'(m), 2'd0, T_MEM, T_MEM, T_BRA);
      check("R1 empty bundle", 3'b000, 1'b0);
    end
  endtask

  task automatic t_single();
    apply(2'd0, 2'd1, T_FPU, T_FPU, T_FPU); check("R2 single mode0", 3'b001, 1'b0);
    apply(2'd1, 2'd1, T_MEM, T_MEM, T_ALU); check("R2 single mem mode1", 3'b001, 1'b0);
    apply(2'd2, 2'd1, T_BRA, T_SHF, T_SHF); check("R2 single branch mode2", 3'b001, 1'b0);
  endtask

  task automatic t_scalar_mode();
    apply(2'd0, 2'd2, T_ALU, T_ALU, T_ALU); check("R3 mode0 pair", 3'b001, 1'b1);
    apply(2'd0, 2'd3, T_ALU, T_NOP, T_ALU); check("R3 mode0 triple", 3'b001, 1'b1);
    apply(2'd3, 2'd2, T_ALU, T_ALU, T_ALU); check("R3 mode3 pair", 3'b001, 1'b1);
  endtask

  task automatic t_dual_lanes();
    apply(2'd1, 2'd2, T_BRA, T_SHF, T_ALU); check("R4 dual shift lane2", 3'b011, 1'b0);
    apply(2'd1, 2'd2, T_FPU, T_CVX, T_ALU); check("R4 dual conv lane2", 3'b011, 1'b0);
    apply(2'd1, 2'd2, T_ALU, T_FPU, T_ALU); check("R4 dual fpu lane2", 3'b001, 1'b1);
    apply(2'd1, 2'd3, T_ALU, T_ALU, T_ALU); check("R4 dual three wide", 3'b001, 1'b1);
  endtask

  task automatic t_dual_mem();
    apply(2'd1, 2'd2, T_MEM, T_ALU, T_ALU); check("R5 dual mem slot0", 3'b001, 1'b1);
    apply(2'd1, 2'd2, T_ALU, T_MEM, T_ALU); check("R5 dual mem slot1", 3'b001, 1'b1);
  endtask

  task automatic t_triple_lanes();
    apply(2'd2, 2'd3, T_BRA, T_SHF, T_CVB); check("R6 triple legal", 3'b111, 1'b0);
    apply(2'd2, 2'd3, T_ALU, T_ALU, T_SHF); check("R6 shift lane3", 3'b001, 1'b1);
    apply(2'd2, 2'd3, T_ALU, T_ALU, T_CVX); check("R6 conv other lane3", 3'b001, 1'b1);
    apply(2'd2, 2'd3, T_ALU, T_CVX, T_NOP); check("R6 conv other lane2", 3'b111, 1'b0);
  endtask

  task automatic t_triple_mem();
    apply(2'd2, 2'd3, T_MEM, T_ALU, T_ALU); check("R7 mem three wide", 3'b001, 1'b1);
    apply(2'd2, 2'd2, T_MEM, T_SHF, T_ALU); check("R7 mem pair", 3'b011, 1'b0);
    apply(2'd2, 2'd2, T_MEM, T_FPU, T_ALU); check("R7 mem plus fpu", 3'b011, 1'b0);
  endtask

  task automatic t_fpu_pair();
    apply(2'd2, 2'd2, T_ALU, T_FPU, T_ALU); check("R8 fpu lane2 alone", 3'b011, 1'b0);
    apply(2'd2, 2'd2, T_FPU, T_FPU, T_ALU); check("R8 fpu both", 3'b001, 1'b1);
    apply(2'd2, 2'd3, T_FPU, T_ALU, T_FPU); check("R8 fpu lane3", 3'b001, 1'b1);
  endtask

  task automatic t_branch();
    apply(2'd2, 2'd2, T_ALU, T_BRA, T_ALU); check("R9 branch lane2", 3'b001, 1'b1);
    apply(2'd2, 2'd3, T_ALU, T_ALU, T_BRA); check("R9 branch lane3", 3'b001, 1'b1);
    apply(2'd2, 2'd3, T_BRA, T_NOP, T_NOP); check("R9 branch lane1", 3'b111, 1'b0);
  endtask

  task automatic t_two_mem();
    apply(2'd2, 2'd2, T_MEM, T_MEM, T_ALU); check("R11 two mem pair", 3'b001, 1'b1);
    apply(2'd2, 2'd3, T_MEM, T_ALU, T_MEM); check("R11 two mem triple", 3'b001, 1'b1);
  endtask

  task automatic t_sweep();
    logic [3:0] r;
    for (int m = 0; m < 4; m++)
      for (int n = 0; n < 4; n++)
        for (int v = 0; v < 512; v++) begin
          apply(2'(m), 2'(n), 3'(v), 3'(v >> 3), 3'(v >> 6));
          r = ref_out(2'(m), 2'(n), 3'(v), 3'(v >> 3), 3'(v >> 6));
          check("R10 sweep", r[2:0], r[3]);
        end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_single();
    t_scalar_mode();
    t_dual_lanes();
    t_dual_mem();
    t_triple_lanes();
    t_triple_mem();
    t_fpu_pair();
    t_branch();
    t_two_mem();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule